// File: doc/BRIEF.md
# Vector Condition Code and Masking Unit

This block keeps the four-lane condition code of a vertex shader and turns it into per-lane write permissions and a branch decision. Each lane of an instruction's FP32 result is classified as negative, zero, positive or unordered (NaN). The 2-bit class is stored in the lane's code register when the instruction asks for an update. An instruction that has no destination can still refresh the code: its write mask is simply all zero.

A consumer instruction supplies a comparison rule, a four-entry swizzle and its own write mask. Lane i tests the stored code component named by swizzle entry i against the rule. A lane is written only when its mask bit is set and the test passes. The branch output is raised when at least one swizzled lane passes, whatever the write mask is. The tests always read the stored code as it was before the clock edge on which the current instruction's update lands.

Top module: `cc_mask_unit`

## Requirements
- R1: While reset is asserted and after it is released, every code component holds the zero class (00). An asynchronous assertion of `rst_n` clears the code immediately.
- R2: Each lane stores a 2-bit class: 00 = zero, 01 = negative, 10 = positive, 11 = unordered. A NaN (all-ones exponent with a nonzero fraction, either sign, quiet or signalling) gives 11. Infinities and denormals are classed by their sign.
- R3: Positive zero (0x00000000) and negative zero (0x80000000) both give the zero class.
- R4: The code changes only on a rising clock edge with `upd_en_i` high. Masks and branch computed in a cycle use the code stored before that edge.
- R5: `rule_i` encodes FL=0, LT=1, EQ=2, LE=3, GT=4, NE=5, GE=6, TR=7. FL never passes, TR always passes, and the others pass on the classes their names give.
- R6: The unordered class passes only NE and TR.
- R7: Lane i tests the stored component whose index is `swz_i[2i+1:2i]`. The value 8'hE4 is the identity swizzle.
- R8: `wmask_o[i]` is `wmask_i[i]` AND the pass result of lane i.
- R9: `br_taken_o` is the OR of the four lane pass results and does not depend on `wmask_i`.
- R10: An update with `wmask_i` = 0 writes no lane in that cycle but still loads the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_i | input | 128 | Instruction result, lane i at bits [32i+31:32i] |
| upd_en_i | input | 1 | Load the code from `res_i` at the next edge |
| rule_i | input | 3 | Comparison rule |
| swz_i | input | 8 | Code swizzle, 2 bits per lane |
| wmask_i | input | 4 | Instruction write mask |
| wmask_o | output | 4 | Effective write mask |
| br_taken_o | output | 1 | Branch condition |

## Verification
The main stimulus is a stored code that holds all four classes at once (positive, negative, zero, NaN). The same code is swept through all eight rules, so each rule's accepted class set is identified lane by lane, and the result for NE versus GE shows how unordered is handled. Further stored codes with signed zeros, denormals, infinities and both NaN kinds separate the sign, exponent and fraction decoding. Broadcast and reversed swizzles separate lane selection from lane position. Directed cases place a pending update beside a test, use an update with no write mask, hold the code with the update disabled, and check a reset applied in the middle of a run.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CC_EQ = 2'b00,
    CC_LT = 2'b01,
    CC_GT = 2'b10,
    CC_UN = 2'b11
  } cc_code_e;

  // bit0 accepts negative, bit1 accepts zero, bit2 accepts positive
  typedef enum logic [2:0] {
    RULE_FL = 3'd0,
    RULE_LT = 3'd1,
    RULE_EQ = 3'd2,
    RULE_LE = 3'd3,
    RULE_GT = 3'd4,
    RULE_NE = 3'd5,
    RULE_GE = 3'd6,
    RULE_TR = 3'd7
  } cc_rule_e;

endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output cc_code_e          code_o
);

  localparam int MAN_W = DATA_W - 1 - EXP_W;

  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    sign = val_i[DATA_W-1];
    expo = val_i[DATA_W-2 -: EXP_W];
    frac = val_i[MAN_W-1:0];
    if ((&expo) && (|frac)) begin
      code_o = CC_UN;
    end else if (~|expo && ~|frac) begin
      code_o = CC_EQ;
    end else if (sign) begin
      code_o = CC_LT;
    end else begin
      code_o = CC_GT;
    end
  end

  // signed zero must never be seen as negative or positive
  always_comb begin
    assert_zero_eq_R3: assert (|val_i[DATA_W-2:0] || code_o == CC_EQ);
  end

endmodule

// File: rtl/cc_rule_eval.sv
module cc_rule_eval
  import cc_pkg::*;
(
  input  cc_code_e code_i,
  input  cc_rule_e rule_i,
  output logic     pass_o
);

  always_comb begin
    case (code_i)
      CC_LT:   pass_o = rule_i[0];
      CC_EQ:   pass_o = rule_i[1];
      CC_GT:   pass_o = rule_i[2];
      CC_UN:   pass_o = (rule_i == RULE_NE) || (rule_i == RULE_TR);
      default: pass_o = 1'b0;
    endcase
  end

  always_comb begin
    assert_un_rule_R6: assert (!(code_i == CC_UN && pass_o) ||
                               rule_i == RULE_NE || rule_i == RULE_TR);
  end

endmodule

// File: rtl/cc_mask_unit.sv
module cc_mask_unit
  import cc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*DATA_W-1:0]   res_i,
  input  logic                      upd_en_i,
  input  logic [2:0]                rule_i,
  input  logic [LANES*$clog2(LANES)-1:0] swz_i,
  input  logic [LANES-1:0]          wmask_i,
  output logic [LANES-1:0]          wmask_o,
  output logic                      br_taken_o
);

  localparam int SEL_W  = $clog2(LANES);
  localparam int CCV_W  = LANES * CODE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // classification of the incoming result
  logic [CCV_W-1:0] new_code;

  for (genvar g = 0; g < LANES; g++) begin : g_cls
    cc_code_e lane_code;
    cc_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls (
      .val_i  (res_i[g*DATA_W +: DATA_W]),
      .code_o (lane_code)
    );
    assign new_code[g*CODE_W +: CODE_W] = lane_code;
  end

  // condition code register
  logic [CCV_W-1:0] cc_q;
  logic [CCV_W-1:0] cc_d;
  logic             cc_en;

  always_comb begin
    cc_en = upd_en_i;
    cc_d  = new_code;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cc_q <= '0;
    end else if (cc_en) begin
      cc_q <= cc_d;
    end
  end

  // swizzle and rule test per lane
  cc_code_e         cc_arr [LANES];
  logic [LANES-1:0] pass;
  cc_rule_e         rule;

  assign rule = cc_rule_e'(rule_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign cc_arr[g] = cc_code_e'(cc_q[g*CODE_W +: CODE_W]);
    assign sel       = swz_i[g*SEL_W +: SEL_W];
    cc_rule_eval u_eval (
      .code_i (cc_arr[sel]),
      .rule_i (rule),
      .pass_o (pass[g])
    );
  end

  assign wmask_o    = wmask_i & pass;
  assign br_taken_o = |pass;

  // assertions
  property p_hold;
    @(posedge clk) disable iff (!rst_sync_n) !upd_en_i |=> $stable(cc_q);
  endproperty
  assert_hold_R4: assert property (p_hold);

  property p_subset;
    @(posedge clk) disable iff (!rst_sync_n) (wmask_o & ~wmask_i) == '0;
  endproperty
  assert_mask_subset_R8: assert property (p_subset);

  property p_never;
    @(posedge clk) disable iff (!rst_sync_n)
      rule_i == RULE_FL |-> (wmask_o == '0) && !br_taken_o;
  endproperty
  assert_never_R5: assert property (p_never);

  property p_always;
    @(posedge clk) disable iff (!rst_sync_n)
      rule_i == RULE_TR |-> (wmask_o == wmask_i) && br_taken_o;
  endproperty
  assert_always_R5: assert property (p_always);

  property p_branch;
    @(posedge clk) disable iff (!rst_sync_n) (wmask_o != '0) |-> br_taken_o;
  endproperty
  assert_branch_R9: assert property (p_branch);

endmodule

// File: tb/cc_mask_unit_bench.sv
module cc_mask_unit_bench;

  localparam logic [31:0] POS1  = 32'h3F800000;
  localparam logic [31:0] NEG2  = 32'hC0000000;
  localparam logic [31:0] PZERO = 32'h00000000;
  localparam logic [31:0] NZERO = 32'h80000000;
  localparam logic [31:0] QNAN  = 32'h7FC00000;
  localparam logic [31:0] NNAN  = 32'hFFC00001;
  localparam logic [31:0] SNAN  = 32'h7F800001;
  localparam logic [31:0] PINF  = 32'h7F800000;
  localparam logic [31:0] NINF  = 32'hFF800000;
  localparam logic [31:0] PDEN  = 32'h00000001;
  localparam logic [31:0] NDEN  = 32'h80000001;
  localparam logic [31:0] NEG1  = 32'hBF800000;

  // lanes {3,2,1,0}: NaN, +0, -2, +1  -> UN, EQ, LT, GT
  localparam logic [127:0] MIX = {QNAN, PZERO, NEG2, POS1};

  typedef struct packed {
    logic [127:0] res;
    logic [2:0]   rule;
    logic [7:0]   swz;
    logic [3:0]   wm;
    logic [3:0]   exp_m;
    logic         exp_b;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{MIX, 3'd4, 8'hE4, 4'hF, 4'b0001, 1'b1},                       // R5 GT
    '{MIX, 3'd1, 8'hE4, 4'hF, 4'b0010, 1'b1},                       // R5 LT
    '{MIX, 3'd2, 8'hE4, 4'hF, 4'b0100, 1'b1},                       // R5 EQ
    '{MIX, 3'd5, 8'hE4, 4'hF, 4'b1011, 1'b1},                       // R6 NE
    '{MIX, 3'd6, 8'hE4, 4'hF, 4'b0101, 1'b1},                       // R6 GE
    '{MIX, 3'd3, 8'hE4, 4'hF, 4'b0110, 1'b1},                       // R5 LE
    '{MIX, 3'd0, 8'hE4, 4'hF, 4'b0000, 1'b0},                       // R5 FL
    '{MIX, 3'd7, 8'hE4, 4'hA, 4'b1010, 1'b1},                       // R8 TR
    '{{PINF, NDEN, PZERO, NZERO}, 3'd2, 8'hE4, 4'hF, 4'b0011, 1'b1}, // R3
    '{{SNAN, NNAN, PDEN, NINF}, 3'd1, 8'hE4, 4'hF, 4'b0001, 1'b1},  // R2
    '{MIX, 3'd4, 8'h00, 4'hF, 4'b1111, 1'b1},                       // R7 .xxxx
    '{MIX, 3'd4, 8'h1B, 4'hF, 4'b1000, 1'b1},                       // R7 .wzyx
    '{MIX, 3'd4, 8'hE4, 4'hE, 4'b0000, 1'b1},                       // R9
    '{{QNAN, QNAN, QNAN, QNAN}, 3'd6, 8'hE4, 4'hF, 4'b0000, 1'b0},  // R6
    '{{QNAN, QNAN, QNAN, QNAN}, 3'd5, 8'hE4, 4'hF, 4'b1111, 1'b1},  // R6
    '{MIX, 3'd1, 8'h55, 4'hF, 4'b1111, 1'b1}                        // R7 .yyyy
  };

  logic         clk;
  logic         rst_n;
  logic [127:0] res_i;
  logic         upd_en_i;
  logic [2:0]   rule_i;
  logic [7:0]   swz_i;
  logic [3:0]   wmask_i;
  logic [3:0]   wmask_o;
  logic         br_taken_o;

  int checks;
  int fails;
  bit done;

  cc_mask_unit u_cc_mask_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_i      (res_i),
    .upd_en_i   (upd_en_i),
    .rule_i     (rule_i),
    .swz_i      (swz_i),
    .wmask_i    (wmask_i),
    .wmask_o    (wmask_o),
    .br_taken_o (br_taken_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] em, input logic eb);
    checks++;
    if (wmask_o !== em || br_taken_o !== eb) begin
      fails++;
      $display("FAIL %s: mask=%b br=%b expected mask=%b br=%b",
               tag, wmask_o, br_taken_o, em, eb);
    end
  endtask

  task automatic load(input logic [127:0] r);
    @(negedge clk);
    res_i    = r;
    upd_en_i = 1'b1;
    wmask_i  = 4'h0;
    @(posedge clk);
    @(negedge clk);
    upd_en_i = 1'b0;
  endtask

  task automatic apply(input logic [2:0] r, input logic [7:0] s, input logic [3:0] w);
    rule_i  = r;
    swz_i   = s;
    wmask_i = w;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    res_i    = '0;
    upd_en_i = 1'b0;
    rule_i   = 3'd0;
    swz_i    = 8'hE4;
    wmask_i  = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset state is all zero class
    apply(3'd2, 8'hE4, 4'hF);
    chk("R1 reset EQ", 4'b1111, 1'b1);
    apply(3'd4, 8'hE4, 4'hF);
    chk("R1 reset GT", 4'b0000, 1'b0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      load(VECS[i].res);
      apply(VECS[i].rule, VECS[i].swz, VECS[i].wm);
      chk($sformatf("R5/R7 table vector %0d", i), VECS[i].exp_m, VECS[i].exp_b);
    end

    // R4: no update without enable
    load(MIX);
    @(negedge clk);
    res_i    = {QNAN, QNAN, QNAN, QNAN};
    upd_en_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    apply(3'd4, 8'hE4, 4'hF);
    chk("R4 hold without enable", 4'b0001, 1'b1);

    // R4: pending update does not affect the current cycle
    res_i    = {NEG1, NEG1, NEG1, NEG1};
    upd_en_i = 1'b1;
    apply(3'd1, 8'hE4, 4'hF);
    chk("R4 old code before edge", 4'b0010, 1'b1);
    @(posedge clk);
    @(negedge clk);
    upd_en_i = 1'b0;
    apply(3'd1, 8'hE4, 4'hF);
    chk("R4 new code after edge", 4'b1111, 1'b1);

    // R10: update with empty write mask
    res_i    = {POS1, POS1, POS1, POS1};
    upd_en_i = 1'b1;
    apply(3'd7, 8'hE4, 4'h0);
    chk("R10 no lane written", 4'b0000, 1'b1);
    @(posedge clk);
    @(negedge clk);
    upd_en_i = 1'b0;
    apply(3'd4, 8'hE4, 4'hF);
    chk("R10 code loaded", 4'b1111, 1'b1);

    // R1: asynchronous reset in mid run
    rst_n = 1'b0;
    apply(3'd2, 8'hE4, 4'hF);
    chk("R1 async reset clears code", 4'b1111, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    apply(3'd4, 8'hE4, 4'hF);
    chk("R1 code still zero after release", 4'b0000, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule